// File: doc/BRIEF.md
# Serial ADC Host Read Controller

This block sits on the host side of a three-wire serial converter link and fetches one 10-bit conversion for each request. A one-cycle start request, together with two channel configuration bits, makes the controller pull chip select low. It then produces the serial clock by dividing the system clock and runs one fixed frame of 16 serial clocks.

Each frame has four parts in this order: a logic-one start bit, the single/differential bit, the odd/sign bit and a dummy zero. Two null clocks follow, and the controller ignores the line during them. The last ten clocks capture the result, most significant bit first.

After the last result bit, chip select goes high again, which lets the converter drop to low supply current. The controller keeps chip select high for at least one serial clock period. It then presents the captured word with a one-cycle valid pulse. A busy flag covers the whole read, and any start request made while busy is high is dropped.

Top module: `adc_read_ctrl`

## Requirements
- R1: After a synchronous reset, even in the middle of a frame, chip select is high, the serial clock is low, busy is low and valid is low.
- R2: A frame has exactly 16 rising serial clock edges while chip select is low. The serial clock period is DIV system clocks. The serial clock is low whenever chip select is high.
- R3: A logic one, the start bit, is on the data-in line from the cycle chip select falls, so the converter samples it at the first rising serial clock edge.
- R4: The converter samples the data-in line on rising edges 2, 3 and 4. It must see the single/differential input there, then the odd/sign input, then 0, and 0 after that. Data-in changes only at falling serial clock edges.
- R5: The levels on the data-out line during rising edges 1 to 6 never reach the result. This includes the two null clocks at edges 5 and 6.
- R6: Data-out is sampled on rising edges 7 to 16. Edge 7 gives result bit 9 and edge 16 gives result bit 0.
- R7: Chip select rises together with the falling serial clock edge that follows rising edge 16.
- R8: Busy rises in the cycle after an accepted start. It stays high until valid pulses for exactly one cycle, with busy low in that cycle. The result output holds its value after the pulse.
- R9: A start request made while busy is high does not change the running frame and does not cause a further frame.
- R10: Between back-to-back frames, chip select stays high for at least DIV system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Read request, accepted only when idle |
| sgl_diff_i | input | 1 | Single/differential configuration bit |
| odd_sign_i | input | 1 | Odd/sign configuration bit |
| miso_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data to the converter |
| busy_o | output | 1 | Read in progress |
| valid_o | output | 1 | One-cycle pulse when the result is available |
| data_o | output | 10 | Last captured result |

## Verification
The converter model drives ones on the data-out line before the result bits, including during the two null clocks. A zero-valued conversion therefore shows up as nonzero if the controller captures from the wrong edge or keeps a null bit. The model records the level on data-in at each rising edge. Swapped configuration bits, a missing start bit or a changing dummy bit appear directly in that record.

One start request is injected mid-frame. A controller that restarted would change the recorded command or count two frames. Back-to-back requests are issued right after valid, and a controller without a deselect wait would show a chip-select-high gap shorter than one serial period. A reset in mid-frame must leave chip select high at once, and the next read must still be correct.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_CMD,
    ST_NULL,
    ST_DATA,
    ST_DESEL,
    ST_DONE
  } rd_state_t;

  localparam int unsigned CMD_BITS  = 4;
  localparam int unsigned NULL_BITS = 2;
endpackage

// File: rtl/adc_half_timer.sv
module adc_half_timer #(
  parameter int unsigned HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;

  assign tick = en && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !en || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/adc_cmd_bits.sv
module adc_cmd_bits #(
  parameter int unsigned IW = 5
) (
  input  logic [IW-1:0] idx,
  input  logic          sgl,
  input  logic          odd,
  output logic          bit_o
);
  always_comb begin
    case (idx)
      IW'(1):  bit_o = 1'b1;
      IW'(2):  bit_o = sgl;
      IW'(3):  bit_o = odd;
      default: bit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/adc_rx_shreg.sv
module adc_rx_shreg #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      q <= '0;
    end else if (shift_en) begin
      q <= {q[W-2:0], din};
    end
  end
endmodule

// File: rtl/adc_read_ctrl.sv
module adc_read_ctrl
  import adc_rd_pkg::*;
#(
  parameter int unsigned DIV   = 4,
  parameter int unsigned RES_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             sgl_diff_i,
  input  logic             odd_sign_i,
  input  logic             miso_i,
  output logic             cs_n_o,
  output logic             sclk_o,
  output logic             mosi_o,
  output logic             busy_o,
  output logic             valid_o,
  output logic [RES_W-1:0] data_o
);
  localparam int unsigned HALF  = DIV / 2;
  localparam int unsigned NBITS = CMD_BITS + NULL_BITS + RES_W;
  localparam int unsigned BCW   = $clog2(NBITS + 1);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(NBITS);
  localparam logic [BCW-1:0] CMD_END  = BCW'(CMD_BITS);
  localparam logic [BCW-1:0] NULL_END = BCW'(CMD_BITS + NULL_BITS);

  rd_state_t        state;
  logic [BCW-1:0]   bitcnt;
  logic [BCW-1:0]   next_idx;
  logic             cfg_sgl, cfg_odd;
  logic             dwait;
  logic             tick;
  logic             timer_en;
  logic             cmd_bit;
  logic             sh_en;
  logic             sh_clr;
  logic [RES_W-1:0] sh_q;

  assign timer_en = (state != ST_IDLE) && (state != ST_DONE);
  assign next_idx = (state == ST_IDLE) ? BCW'(1) : bitcnt + 1'b1;
  assign sh_en    = tick && !sclk_o && (state == ST_DATA);
  assign sh_clr   = (state == ST_IDLE) && start_i;

  adc_half_timer #(.HALF(HALF)) u_timer (
    .clk (clk),
    .rst (rst),
    .en  (timer_en),
    .tick(tick)
  );

  adc_cmd_bits #(.IW(BCW)) u_cmd (
    .idx  (next_idx),
    .sgl  ((state == ST_IDLE) ? sgl_diff_i : cfg_sgl),
    .odd  ((state == ST_IDLE) ? odd_sign_i : cfg_odd),
    .bit_o(cmd_bit)
  );

  adc_rx_shreg #(.W(RES_W)) u_rx (
    .clk     (clk),
    .rst     (rst),
    .clr     (sh_clr),
    .shift_en(sh_en),
    .din     (miso_i),
    .q       (sh_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cs_n_o  <= 1'b1;
      sclk_o  <= 1'b0;
      mosi_o  <= 1'b0;
      busy_o  <= 1'b0;
      valid_o <= 1'b0;
      data_o  <= '0;
      bitcnt  <= '0;
      cfg_sgl <= 1'b0;
      cfg_odd <= 1'b0;
      dwait   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start_i) begin
            state   <= ST_SETUP;
            cs_n_o  <= 1'b0;
            busy_o  <= 1'b1;
            cfg_sgl <= sgl_diff_i;
            cfg_odd <= odd_sign_i;
            mosi_o  <= cmd_bit;
            bitcnt  <= '0;
          end
        end
        ST_SETUP: begin
          if (tick) begin
            sclk_o <= 1'b1;
            bitcnt <= BCW'(1);
            state  <= ST_CMD;
          end
        end
        ST_CMD, ST_NULL, ST_DATA: begin
          if (tick) begin
            if (sclk_o) begin
              sclk_o <= 1'b0;
              if (bitcnt == LAST_BIT) begin
                cs_n_o <= 1'b1;
                mosi_o <= 1'b0;
                dwait  <= 1'b0;
                state  <= ST_DESEL;
              end else begin
                mosi_o <= cmd_bit;
                if (next_idx <= CMD_END) begin
                  state <= ST_CMD;
                end else if (next_idx <= NULL_END) begin
                  state <= ST_NULL;
                end else begin
                  state <= ST_DATA;
                end
              end
            end else begin
              sclk_o <= 1'b1;
              bitcnt <= bitcnt + 1'b1;
            end
          end
        end
        ST_DESEL: begin
          if (tick) begin
            if (dwait) begin
              state <= ST_DONE;
            end else begin
              dwait <= 1'b1;
            end
          end
        end
        ST_DONE: begin
          valid_o <= 1'b1;
          busy_o  <= 1'b0;
          data_o  <= sh_q;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_read_ctrl_chk.sv
module adc_read_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic start_i,
  input logic cs_n_o,
  input logic sclk_o,
  input logic mosi_o,
  input logic busy_o,
  input logic valid_o
);
  AST_DESEL_SCLK_LOW: assert property (@(posedge clk) disable iff (rst)
    cs_n_o |-> !sclk_o); // R2

  AST_START_BIT_FIRST: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n_o) |-> mosi_o); // R3

  AST_MOSI_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk_o) |-> $stable(mosi_o)); // R4

  AST_IDLE_DESELECTED: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> cs_n_o); // R7

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o); // R8

  AST_VALID_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (!busy_o && $past(busy_o))); // R8

  AST_ACCEPT_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n_o) |-> $past(!busy_o && start_i)); // R9
endmodule

bind adc_read_ctrl adc_read_ctrl_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .start_i(start_i),
  .cs_n_o (cs_n_o),
  .sclk_o (sclk_o),
  .mosi_o (mosi_o),
  .busy_o (busy_o),
  .valid_o(valid_o)
);

// File: tb/tb_adc_read_ctrl.sv
`timescale 1ns/1ps
module tb_adc_read_ctrl;
  localparam int DIV = 4;
  localparam int W   = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, sgl_diff_i = 1'b0, odd_sign_i = 1'b0;
  logic miso_i = 1'b0;
  logic cs_n_o, sclk_o, mosi_o, busy_o, valid_o;
  logic [W-1:0] data_o;

  always #5 clk = ~clk;

  adc_read_ctrl #(.DIV(DIV), .RES_W(W)) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .sgl_diff_i(sgl_diff_i),
    .odd_sign_i(odd_sign_i), .miso_i(miso_i), .cs_n_o(cs_n_o),
    .sclk_o(sclk_o), .mosi_o(mosi_o), .busy_o(busy_o),
    .valid_o(valid_o), .data_o(data_o)
  );

  int checks = 0;
  int errors = 0;

  // converter model
  int       rises = 0;
  int       frames = 0;
  int       end_rises = 0;
  int       per_bad = 0;
  logic     rec [1:16];
  logic [W-1:0] model_val = '0;
  time      t_last_rise = 0;
  time      t_cs_rise = 0;
  time      min_hi = 1000000;
  bit       have_rise = 0;

  always @(negedge cs_n_o) begin
    rises = 0;
    frames++;
    miso_i = 1'b1;
    if (have_rise && ($time - t_cs_rise) < min_hi) min_hi = $time - t_cs_rise;
  end

  always @(posedge cs_n_o) begin
    end_rises = rises;
    t_cs_rise = $time;
    have_rise = 1;
  end

  always @(posedge sclk_o) begin
    if (cs_n_o === 1'b0) begin
      rises++;
      if (rises <= 16) rec[rises] = mosi_o;
      if (rises > 1 && ($time - t_last_rise) != DIV * 10) per_bad++;
      t_last_rise = $time;
    end
  end

  always @(negedge sclk_o) begin
    if (cs_n_o === 1'b0) begin
      if (rises >= 6 && rises <= 15) miso_i = model_val[15 - rises];
      else if (rises < 6) miso_i = 1'b1;
      else miso_i = 1'b0;
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_valid(output bit seen);
    seen = 0;
    for (int i = 0; i < 2000; i++) begin
      @(posedge clk); #1;
      if (valid_o) begin seen = 1; break; end
    end
  endtask

  task automatic pulse_start(input logic s, input logic o);
    @(negedge clk);
    sgl_diff_i = s; odd_sign_i = o; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic run_frame(input logic s, input logic o, input logic [W-1:0] v);
    bit seen;
    int f0;
    f0 = frames;
    model_val = v;
    pulse_start(s, o);
    chk(busy_o === 1'b1, "R8 busy after start", int'(busy_o), 1);
    wait_valid(seen);
    chk(seen, "R8 valid seen", int'(seen), 1);
    chk(busy_o === 1'b0, "R8 busy low at valid", int'(busy_o), 0);
    chk(data_o === v, "R6 result", int'(data_o), int'(v));
    if (v == '0) chk(data_o === '0, "R5 null bits dropped", int'(data_o), 0);
    chk(rec[1] === 1'b1, "R3 start bit", int'(rec[1]), 1);
    chk(rec[2] === s && rec[3] === o && rec[4] === 1'b0, "R4 command bits",
        int'({rec[2], rec[3], rec[4]}), int'({s, o, 1'b0}));
    chk(end_rises == 16, "R7 cs rise after edge 16", end_rises, 16);
    chk(frames == f0 + 1, "R2 one frame", frames, f0 + 1);
    chk(cs_n_o === 1'b1, "R7 cs high at end", int'(cs_n_o), 1);
  endtask

  localparam logic [11:0] VEC [0:5] = '{
    12'hAAA, 12'h5FF, 12'hC00, 12'h3FF, 12'h601, 12'h955
  };

  initial begin
    bit seen;
    int f0;
    logic [W-1:0] after;
    repeat (3) @(posedge clk);
    #1;
    chk(cs_n_o === 1'b1 && sclk_o === 1'b0 && busy_o === 1'b0 && valid_o === 1'b0,
        "R1 reset state", int'({cs_n_o, sclk_o, busy_o, valid_o}), 8);
    @(negedge clk); rst = 1'b0;
    repeat (2) @(negedge clk);

    // vector table walk, back to back
    for (int i = 0; i < 6; i++) begin
      run_frame(VEC[i][11], VEC[i][10], VEC[i][9:0]);
    end
    chk(per_bad == 0, "R2 sclk period", per_bad, 0);
    chk(min_hi >= DIV * 10, "R10 cs high gap", int'(min_hi), DIV * 10);

    // result holds after valid pulse
    after = data_o;
    @(posedge clk); #1;
    chk(valid_o === 1'b0, "R8 valid single cycle", int'(valid_o), 0);
    repeat (5) @(posedge clk); #1;
    chk(data_o === after, "R8 result holds", int'(data_o), int'(after));

    // start while busy ignored
    f0 = frames;
    model_val = 10'h1C3;
    pulse_start(1'b0, 1'b1);
    repeat (20) @(negedge clk);
    sgl_diff_i = 1'b1; odd_sign_i = 1'b0; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    wait_valid(seen);
    chk(data_o === 10'h1C3, "R9 frame intact result", int'(data_o), 'h1C3);
    chk(rec[2] === 1'b0 && rec[3] === 1'b1, "R9 frame intact command",
        int'({rec[2], rec[3]}), 1);
    repeat (60) @(posedge clk); #1;
    chk(frames == f0 + 1, "R9 no extra frame", frames, f0 + 1);
    chk(cs_n_o === 1'b1 && busy_o === 1'b0, "R9 idle after", int'({cs_n_o, busy_o}), 2);

    // reset in mid frame
    pulse_start(1'b1, 1'b1);
    repeat (14) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(cs_n_o === 1'b1 && sclk_o === 1'b0 && busy_o === 1'b0 && valid_o === 1'b0,
        "R1 mid-frame reset", int'({cs_n_o, sclk_o, busy_o, valid_o}), 8);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    run_frame(1'b1, 1'b1, 10'h2C5);
    chk(per_bad == 0, "R2 sclk period final", per_bad, 0);

    finish_run();
  end
endmodule